// File: doc/BRIEF.md
# E1 Timeslot-Zero Spare-Bit Data Link

This block carries a low-rate serial maintenance channel in the five spare bit positions (Sa4 to Sa8) of E1 timeslot zero. These bits ride only in the frames that do not carry the frame-alignment word, which are every second frame. A 5-bit select word decides which spare positions belong to the channel. Each selected position adds 4 kb/s, so the channel runs at 4, 8, 12, 16 or 20 kb/s.

On the transmit side the block watches the serial 2.048 Mb/s stream that is about to leave. At each selected spare position it raises a one-bit-period strobe, `tx_dlclk`. It captures the caller's `tx_dl` bit at the end of that strobe and writes it over the stream bit. All other bits pass through with a fixed two-cycle delay. On the receive side it picks the selected spare bits out of the decoded receive stream. It presents each one on `rx_dl`, together with a strobe `rx_dlclk` that changes in the same cycle.

Each side has its own frame-start pulse and an odd/even flag that marks the frames carrying spare bits. Frame bit index 0 is the cycle in which the frame-start pulse is high. Spare bits Sa4 to Sa8 sit at frame bit indices 3 to 7.

Top module: `e1_sa_link`

## Requirements
- R1: While reset is asserted and after it is released, `tx_dlclk`, `tx_dout`, `rx_dlclk` and `rx_dl` are 0 and the select word is 0.
- R2: When `sel_we` is high, `sel_wdata` is loaded and takes effect from the next cycle. Bit 4 selects Sa4 (frame index 3), bit 3 selects Sa5, bit 2 Sa6, bit 1 Sa7 and bit 0 Sa8 (frame index 7).
- R3: `tx_dlclk` is high for exactly one cycle: the cycle that follows each transmit input cycle at a selected spare index in a spare-bit frame. It is low in every other cycle.
- R4: With a select word of 0, neither strobe ever pulses and the transmit stream is passed through unchanged.
- R5: `tx_dout` equals `tx_din` delayed by two cycles. The exception is a selected spare slot: there `tx_dout` carries the `tx_dl` value present during the cycle in which `tx_dlclk` was high. `tx_dl` has no effect in any other cycle.
- R6: Frame-alignment frames (flag low at frame start) and unselected spare positions pass through untouched.
- R7: `rx_dlclk` is high for one cycle after each receive input cycle at a selected spare index in a spare-bit frame. In that same cycle `rx_dl` shows the `rx_din` bit taken from that slot.
- R8: `rx_dl` holds its value in every cycle in which `rx_dlclk` is low.
- R9: Channel bits leave and arrive in the order Sa4, Sa5, Sa6, Sa7, Sa8, skipping unselected positions.
- R10: The odd/even flag is sampled in the frame-start cycle and applies to the whole frame. Before the first frame-start pulse after reset, no strobe pulses.
- R11: In each spare-bit frame, each strobe pulses exactly as many times as there are ones in the select word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 2.048 MHz bit clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| sel_we | input | 1 | Load strobe for the select word |
| sel_wdata | input | 5 | New select word (bit 4 = Sa4 ... bit 0 = Sa8) |
| tx_fsync | input | 1 | Transmit frame start, high at frame bit index 0 |
| tx_nfas | input | 1 | Transmit frame carries spare bits (sampled at frame start) |
| tx_din | input | 1 | Outgoing serial stream before insertion |
| tx_dl | input | 1 | Data-link bit to insert, taken while `tx_dlclk` is high |
| tx_dlclk | output | 1 | Gapped transmit data-link strobe |
| tx_dout | output | 1 | Outgoing serial stream after insertion |
| rx_fsync | input | 1 | Receive frame start, high at frame bit index 0 |
| rx_nfas | input | 1 | Receive frame carries spare bits (sampled at frame start) |
| rx_din | input | 1 | Decoded receive serial stream |
| rx_dlclk | output | 1 | Gapped receive data-link strobe |
| rx_dl | output | 1 | Extracted data-link bit |

## Verification
The bench builds the block with `FRAME_BITS` set to 32 instead of 256, and keeps the spare positions at their default indices 3 to 7. The short frame means every select word, both frame kinds and runs of back-to-back spare bits are covered in a few hundred cycles. The strobe at index 7 still lands well inside the frame, so pulse counts per frame stay unambiguous. The counter wrap is also exercised many times.

// File: rtl/e1dl_pkg.sv
package e1dl_pkg;

  // Frame bit index of the first spare bit, and how many spare bits follow it.
  localparam int SA_FIRST_IDX = 3;
  localparam int SA_NUM       = 5;

  // One stage of the transmit pipeline: the stream bit and whether it is replaced.
  typedef struct packed {
    logic take;
    logic bit_v;
  } e1dl_stage_t;

endpackage

// File: rtl/e1dl_frame_pos.sv
module e1dl_frame_pos #(
  parameter int FRAME_BITS = 256,
  parameter int SA_FIRST   = 3,
  parameter int SA_COUNT   = 5
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                fsync,
  input  logic                nfas,
  output logic [SA_COUNT-1:0] slot_vec
);

  localparam int CW = (FRAME_BITS > 2) ? $clog2(FRAME_BITS) : 1;
  localparam logic [CW-1:0] LAST_IDX = CW'(FRAME_BITS - 1);

  logic [CW-1:0] cnt_q, cnt_d, cur_idx;
  logic          nfas_q, nfas_d, cur_nfas;
  logic          lock_q, lock_d, cur_valid;

  // Position of the bit on the input this cycle
  always_comb begin
    cur_idx   = fsync ? '0 : cnt_q;
    cur_nfas  = fsync ? nfas : nfas_q;
    cur_valid = fsync | lock_q;
    cnt_d     = (cur_idx == LAST_IDX) ? '0 : cur_idx + 1'b1;
    nfas_d    = cur_nfas;
    lock_d    = cur_valid;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      nfas_q <= 1'b0;
      lock_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      nfas_q <= nfas_d;
      lock_q <= lock_d;
    end
  end

  // slot_vec[k] marks the spare bit whose select bit is k (k = SA_COUNT-1 is first)
  for (genvar k = 0; k < SA_COUNT; k++) begin : g_slot
    localparam logic [CW-1:0] POS = CW'(SA_FIRST + SA_COUNT - 1 - k);
    assign slot_vec[k] = cur_valid & cur_nfas & (cur_idx == POS);
  end

  // R10
  fpos_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fsync |=> (cnt_q == CW'(1)));

endmodule

// File: rtl/e1dl_tx_insert.sv
module e1dl_tx_insert #(
  parameter int SA_COUNT = 5
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [SA_COUNT-1:0] slot_vec,
  input  logic [SA_COUNT-1:0] sel,
  input  logic                tx_din,
  input  logic                tx_dl,
  output logic                tx_dlclk,
  output logic                tx_dout
);

  import e1dl_pkg::*;

  e1dl_stage_t st_q, st_d;
  logic        out_q, out_d;

  always_comb begin
    st_d.take  = |(slot_vec & sel);
    st_d.bit_v = tx_din;
    out_d      = st_q.take ? tx_dl : st_q.bit_v;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= '0;
      out_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      out_q <= out_d;
    end
  end

  assign tx_dlclk = st_q.take;
  assign tx_dout  = out_q;

endmodule

// File: rtl/e1dl_rx_extract.sv
module e1dl_rx_extract #(
  parameter int SA_COUNT = 5
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [SA_COUNT-1:0] slot_vec,
  input  logic [SA_COUNT-1:0] sel,
  input  logic                rx_din,
  output logic                rx_dlclk,
  output logic                rx_dl
);

  logic hit;
  logic clk_q, clk_d;
  logic dl_q, dl_d;

  always_comb begin
    hit   = |(slot_vec & sel);
    clk_d = hit;
    dl_d  = hit ? rx_din : dl_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clk_q <= 1'b0;
      dl_q  <= 1'b0;
    end else begin
      clk_q <= clk_d;
      dl_q  <= dl_d;
    end
  end

  assign rx_dlclk = clk_q;
  assign rx_dl    = dl_q;

  // R8
  rxdl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_dlclk |-> $stable(rx_dl));

  // R7
  rxdl_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_dlclk |-> (rx_dl == $past(rx_din)));

endmodule

// File: rtl/e1_sa_link.sv
module e1_sa_link #(
  parameter int FRAME_BITS = 256,
  parameter int SA_FIRST   = e1dl_pkg::SA_FIRST_IDX,
  parameter int SA_COUNT   = e1dl_pkg::SA_NUM
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sel_we,
  input  logic [SA_COUNT-1:0] sel_wdata,
  input  logic                tx_fsync,
  input  logic                tx_nfas,
  input  logic                tx_din,
  input  logic                tx_dl,
  output logic                tx_dlclk,
  output logic                tx_dout,
  input  logic                rx_fsync,
  input  logic                rx_nfas,
  input  logic                rx_din,
  output logic                rx_dlclk,
  output logic                rx_dl
);

  logic [SA_COUNT-1:0] sel_q, sel_d;
  logic [SA_COUNT-1:0] tx_slots, rx_slots;

  always_comb begin
    sel_d = sel_we ? sel_wdata : sel_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sel_q <= '0;
    else        sel_q <= sel_d;
  end

  e1dl_frame_pos #(.FRAME_BITS(FRAME_BITS), .SA_FIRST(SA_FIRST), .SA_COUNT(SA_COUNT)) u_tx_pos (
    .clk(clk), .rst_n(rst_n), .fsync(tx_fsync), .nfas(tx_nfas), .slot_vec(tx_slots)
  );

  e1dl_frame_pos #(.FRAME_BITS(FRAME_BITS), .SA_FIRST(SA_FIRST), .SA_COUNT(SA_COUNT)) u_rx_pos (
    .clk(clk), .rst_n(rst_n), .fsync(rx_fsync), .nfas(rx_nfas), .slot_vec(rx_slots)
  );

  e1dl_tx_insert #(.SA_COUNT(SA_COUNT)) u_tx (
    .clk(clk), .rst_n(rst_n), .slot_vec(tx_slots), .sel(sel_q),
    .tx_din(tx_din), .tx_dl(tx_dl), .tx_dlclk(tx_dlclk), .tx_dout(tx_dout)
  );

  e1dl_rx_extract #(.SA_COUNT(SA_COUNT)) u_rx (
    .clk(clk), .rst_n(rst_n), .slot_vec(rx_slots), .sel(sel_q),
    .rx_din(rx_din), .rx_dlclk(rx_dlclk), .rx_dl(rx_dl)
  );

  // R4
  txclk_needs_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_q == '0) |=> !tx_dlclk);

  // R4
  rxclk_needs_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_q == '0) |=> !rx_dlclk);

  // R11
  txclk_sel_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_dlclk |-> ($countones($past(sel_q)) != 0));

endmodule

// File: tb/sim_e1_sa_link.sv
`timescale 1ns/1ps
module sim_e1_sa_link;

  localparam int FB = 32;

  logic clk = 1'b0;
  logic rst_n;
  logic sel_we;
  logic [4:0] sel_wdata;
  logic tx_fsync, tx_nfas, tx_din, tx_dl, tx_dlclk, tx_dout;
  logic rx_fsync, rx_nfas, rx_din, rx_dlclk, rx_dl;

  always #2 clk = ~clk;

  e1_sa_link #(.FRAME_BITS(FB)) u0 (
    .clk(clk), .rst_n(rst_n), .sel_we(sel_we), .sel_wdata(sel_wdata),
    .tx_fsync(tx_fsync), .tx_nfas(tx_nfas), .tx_din(tx_din), .tx_dl(tx_dl),
    .tx_dlclk(tx_dlclk), .tx_dout(tx_dout),
    .rx_fsync(rx_fsync), .rx_nfas(rx_nfas), .rx_din(rx_din),
    .rx_dlclk(rx_dlclk), .rx_dl(rx_dl)
  );

  int nchk = 0;
  int nfail = 0;

  // Behavioural model state
  int       m_cnt = 0;
  bit       m_lock = 0, m_nfas = 0;
  bit [4:0] m_sel = 0;
  bit       m_txclk = 0, m_dout = 0, m_din_d1 = 0, m_rxclk = 0, m_rxdl = 0;
  bit [15:0] lfsr = 16'hACE1;
  bit       rx_pat_en = 0;
  bit [4:0] rx_pat = 0;
  int       txp = 0, rxp = 0;
  bit [7:0] rxcap = 0;

  task automatic chk(input string req, input logic act, input logic exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s act=%0b exp=%0b t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic chk_int(input string req, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s act=%0d exp=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  endtask

  // One bit period: check outputs, then drive inputs and advance the model
  task automatic cyc(input bit fs, input bit nf, input bit we, input bit [4:0] wv);
    int  idx;
    bit  cur_n, val, hit, tdin, rdin, dlb, nxt;
    @(negedge clk);
    chk("R3 tx_dlclk", tx_dlclk, m_txclk);
    chk("R5 tx_dout", tx_dout, m_dout);
    chk("R7 rx_dlclk", rx_dlclk, m_rxclk);
    chk("R8 rx_dl", rx_dl, m_rxdl);
    if (tx_dlclk) txp++;
    if (rx_dlclk) begin rxp++; rxcap = {rxcap[6:0], rx_dl}; end
    idx   = fs ? 0 : m_cnt;
    cur_n = fs ? nf : m_nfas;
    val   = fs | m_lock;
    lfsr  = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    tdin  = lfsr[0];
    dlb   = lfsr[9];
    rdin  = (rx_pat_en && idx >= 3 && idx <= 7) ? rx_pat[7-idx] : lfsr[5];
    tx_fsync = fs; rx_fsync = fs; tx_nfas = nf; rx_nfas = nf;
    tx_din = tdin; rx_din = rdin; tx_dl = dlb;
    sel_we = we; sel_wdata = wv;
    hit = val && cur_n && idx >= 3 && idx <= 7 && m_sel[7-idx];
    nxt = m_txclk ? dlb : m_din_d1;
    m_dout   = nxt;
    m_din_d1 = tdin;
    m_txclk  = hit;
    m_rxclk  = hit;
    if (hit) m_rxdl = rdin;
    m_cnt = (idx + 1) % FB;
    if (fs) begin m_nfas = nf; m_lock = 1; end
    if (we) m_sel = wv;
  endtask

  task automatic frame(input bit nf);
    for (int i = 0; i < FB; i++) cyc(i == 0, nf, 1'b0, 5'd0);
  endtask

  task automatic write_sel(input bit [4:0] v);
    cyc(1'b0, 1'b0, 1'b1, v);
  endtask

  task automatic clr_counts();
    txp = 0; rxp = 0; rxcap = 0;
  endtask

  task automatic t_reset();
    rst_n = 1'b0; sel_we = 0; sel_wdata = 0;
    tx_fsync = 0; tx_nfas = 0; tx_din = 0; tx_dl = 0;
    rx_fsync = 0; rx_nfas = 0; rx_din = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 tx_dlclk reset", tx_dlclk, 1'b0);
    chk("R1 tx_dout reset", tx_dout, 1'b0);
    chk("R1 rx_dlclk reset", rx_dlclk, 1'b0);
    chk("R1 rx_dl reset", rx_dl, 1'b0);
    rst_n = 1'b1;
  endtask

  // R10: no strobes before the first frame start, even with everything selected
  task automatic t_no_sync();
    write_sel(5'h1F);
    clr_counts();
    for (int i = 0; i < 40; i++) cyc(1'b0, 1'b1, 1'b0, 5'd0);
    chk_int("R10 tx pulses before sync", txp, 0);
    chk_int("R10 rx pulses before sync", rxp, 0);
  endtask

  // R11 / R3 / R5: each rate, back to back spare bits
  task automatic t_rates();
    bit [4:0] pats [5] = '{5'b10000, 5'b11000, 5'b11100, 5'b11110, 5'b11111};
    for (int p = 0; p < 5; p++) begin
      write_sel(pats[p]);
      frame(1'b0);
      clr_counts();
      frame(1'b1);
      chk_int("R11 tx pulse count", txp, $countones(pats[p]));
      chk_int("R11 rx pulse count", rxp, $countones(pats[p]));
    end
  endtask

  // R6: frame-alignment frames untouched; R10 flag held for whole frame
  task automatic t_fas_pass();
    write_sel(5'h1F);
    clr_counts();
    frame(1'b0);
    frame(1'b0);
    chk_int("R6 no pulses in alignment frames", txp, 0);
    chk_int("R10 rx no pulses in alignment frames", rxp, 0);
  endtask

  // R4: select word zero
  task automatic t_sel_zero();
    write_sel(5'h00);
    clr_counts();
    frame(1'b1);
    frame(1'b0);
    frame(1'b1);
    chk_int("R4 tx pulses with zero select", txp, 0);
    chk_int("R4 rx pulses with zero select", rxp, 0);
  endtask

  // R9: order of bits with gaps
  task automatic t_order();
    rx_pat_en = 1;
    write_sel(5'b10101);
    rx_pat = 5'b10011;
    clr_counts();
    frame(1'b1);
    chk_int("R9 order Sa4,Sa6,Sa8 pattern A", int'(rxcap[2:0]), 3'b101);
    rx_pat = 5'b01110;
    clr_counts();
    frame(1'b1);
    chk_int("R9 order Sa4,Sa6,Sa8 pattern B", int'(rxcap[2:0]), 3'b010);
    rx_pat = 5'b11001;
    write_sel(5'b01011);
    clr_counts();
    frame(1'b1);
    chk_int("R9 order Sa5,Sa7,Sa8", int'(rxcap[2:0]), 3'b101);
    rx_pat_en = 0;
  endtask

  // R2: select bit mapping at both ends
  task automatic t_sel_map();
    rx_pat_en = 1;
    write_sel(5'b00001);
    rx_pat = 5'b00001;
    clr_counts();
    frame(1'b1);
    chk_int("R2 bit0 selects Sa8 count", rxp, 1);
    chk_int("R2 bit0 selects Sa8 value", int'(rxcap[0]), 1);
    rx_pat = 5'b11110;
    clr_counts();
    frame(1'b1);
    chk_int("R2 bit0 ignores Sa4..Sa7", int'(rxcap[0]), 0);
    write_sel(5'b10000);
    rx_pat = 5'b10000;
    clr_counts();
    frame(1'b1);
    chk_int("R2 bit4 selects Sa4 value", int'(rxcap[0]), 1);
    rx_pat = 5'b01111;
    clr_counts();
    frame(1'b1);
    chk_int("R2 bit4 ignores Sa5..Sa8", int'(rxcap[0]), 0);
    rx_pat_en = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog expired t=%0t", $time);
    finish_run();
  end

  initial begin
    t_reset();
    t_no_sync();
    t_rates();
    t_fas_pass();
    t_sel_zero();
    t_order();
    t_sel_map();
    frame(1'b0);
    finish_run();
  end

endmodule